// File: doc/BRIEF.md
# Daisy-Chained Frame Sync Controller

This block is the framing logic of a codec-style device's serial port. The port may share one serial bus with up to seven other devices that form a chain. In master mode the block generates its own frame sync pulse and paces a round of time slots, one slot per device on the chain. In slave mode the frame sync arrives as an input from the previous device. In both modes the block produces a delayed frame sync that becomes the frame sync input of the next device in the chain. It also shifts out one data word per frame and drives an output enable. While that enable is low, the data pin is meant to be tri-stated.

A round of primary frames is always sent. A secondary round follows it only when the host asks for one. In a secondary frame the block sends the secondary word if one is valid, and otherwise an all-zero word. The all-zero word is a no-op, an access of value zero to address zero, so the slot is still filled. In slave mode the last bit of each word is cleared. When slaves run with the short spacing, they hold off turning on their data driver until half a bit time after the rising clock edge.

Top module: `frame_relay_port`

## Requirements
- R1: While reset is asserted, fsOut, fsdOut, sdoEn, sdo and secFrame are all 0.
- R2: In master mode (isMaster=1), fsOut is a single-cycle pulse repeating every (chainLen+1)*G cycles. G is 16 when longSpacing=0 and 32 when longSpacing=1. chainLen ranges 0..7, for up to eight devices.
- R3: In master mode, fsdOut is a single-cycle pulse exactly G cycles after each fsOut pulse.
- R4: In slave mode (isMaster=0), fsOut stays 0. If fsIn is high in cycle c, fsdOut pulses for one cycle in cycle c+16, whatever the value of longSpacing.
- R5: After a frame sync in cycle c (fsOut in master mode, fsIn in slave mode), sdoEn is high for exactly the 16 cycles c+1..c+16. During those cycles sdo carries the frame word, most significant bit first. Outside such a window sdoEn is 0.
- R6: In slave mode, bit 0 of every transmitted word (the 16th bit sent) is 0.
- R7: A primary frame carries txPri. A secondary frame carries txSec when secValid=1, and all zeros (no-op) when secValid=0.
- R8: In master mode, the first round after reset is primary. A secondary round follows a primary round only if secReq=1 in the round's last cycle, and a secondary round is always followed by a primary one. secFrame is 1 for the window of a secondary frame.
- R9: In slave mode, the frame started by fsIn is secondary when secReq=1 in the same cycle. secFrame reports this during the window.
- R10: In slave mode with longSpacing=0, sdoEn stays 0 during the first half of the first window cycle and rises at that cycle's falling clock edge. In master mode, or with longSpacing=1, sdoEn is high from the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 = generate frame sync, 0 = accept frame sync on fsIn |
| longSpacing | input | 1 | Slot spacing: 0 = 16 clocks, 1 = 32 clocks |
| chainLen | input | 3 | Number of devices on the chain minus one |
| secReq | input | 1 | Master: request a secondary round; slave: marks the incoming frame secondary |
| secValid | input | 1 | Secondary word valid; 0 sends a no-op zero word |
| txPri | input | 16 | Primary frame word |
| txSec | input | 16 | Secondary frame word |
| fsIn | input | 1 | Frame sync input (slave mode) |
| fsOut | output | 1 | Generated frame sync (master mode) |
| fsdOut | output | 1 | Delayed frame sync to the next device |
| sdo | output | 1 | Serial data bit |
| sdoEn | output | 1 | Data driver enable (0 = tri-state) |
| secFrame | output | 1 | Current window belongs to a secondary frame |

## Verification
The bench uses the default parameters: 16-bit words, spacings of 16 and 32 clocks, a slave relay delay of 16 and a limit of eight devices. With these, both spacings can be reached by flipping one input. A chain length of two gives a 96-cycle master round in which the delayed sync, the data window and the next frame sync all land at distinct cycles. A chain length of zero makes the window of one frame run straight into the next, which is where the alternation of primary and secondary frames and the no-op zero word are observed. A bench sample taken in the first half of a bit time makes the half-cycle hold-off of a slave's driver visible.

// File: rtl/frame_relay_pkg.sv
package frame_relay_pkg;

  // Strobes from control to datapath, valid in the frame sync cycle
  typedef struct packed {
    logic frameStart;  // own frame sync seen this cycle
    logic frameSec;    // frame is a secondary frame
    logic delayLong;   // relay delay uses the long spacing
    logic slaveFrame;  // frame was started by an external sync
    logic lateTurnOn;  // hold off driver enable by half a bit time
  } relayStrobe_t;

endpackage

// File: rtl/frame_relay_ctrl.sv
module frame_relay_ctrl
  import frame_relay_pkg::*;
#(
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 32,
  parameter int MAX_DEV   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       isMaster,
  input  logic                       longSpacing,
  input  logic [$clog2(MAX_DEV)-1:0] chainLen,
  input  logic                       secReq,
  input  logic                       fsIn,
  output logic                       fsOut,
  output relayStrobe_t               strobe
);

  localparam int CNT_W  = $clog2(LONG_GAP);
  localparam int SLOT_W = $clog2(MAX_DEV);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_GAP - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_GAP - 1);

  logic              primed;
  logic [CNT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              roundSec;
  logic              lastBit;
  logic              lastSlot;
  logic [CNT_W-1:0]  gapLast;

  always_comb begin
    gapLast  = longSpacing ? LONG_LAST : SHORT_LAST;
    lastBit  = (bitCnt >= gapLast);
    lastSlot = (slotCnt >= chainLen);
  end

  // Master round timing: bit counter inside a slot, slot counter inside a round
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      bitCnt   <= '0;
      slotCnt  <= '0;
      roundSec <= 1'b0;
    end else if (!isMaster) begin
      primed   <= 1'b0;
      bitCnt   <= '0;
      slotCnt  <= '0;
      roundSec <= 1'b0;
    end else if (!primed) begin
      primed <= 1'b1;
    end else if (lastBit) begin
      bitCnt <= '0;
      if (lastSlot) begin
        slotCnt  <= '0;
        roundSec <= !roundSec && secReq;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    fsOut             = isMaster && primed && (bitCnt == '0) && (slotCnt == '0);
    strobe.frameStart = isMaster ? fsOut : fsIn;
    strobe.frameSec   = isMaster ? roundSec : secReq;
    strobe.delayLong  = isMaster && longSpacing;
    strobe.slaveFrame = !isMaster;
    strobe.lateTurnOn = !isMaster && !longSpacing;
  end

  // R2
  fs_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsOut |=> !fsOut);

  // R8
  sec_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && primed && lastBit && lastSlot && roundSec) |=> !roundSec);

endmodule

// File: rtl/frame_relay_datapath.sv
module frame_relay_datapath
  import frame_relay_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 32,
  parameter int SLAVE_GAP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  relayStrobe_t      strobe,
  input  logic              secValid,
  input  logic [WORD_W-1:0] txPri,
  input  logic [WORD_W-1:0] txSec,
  output logic              fsdOut,
  output logic              sdo,
  output logic              sdoEn,
  output logic              secFrame
);

  localparam int WND_W = $clog2(WORD_W + 1);
  localparam int DLY_W = $clog2(LONG_GAP + 1);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] loadWord;
  logic [WND_W-1:0]  wndCnt;
  logic [DLY_W-1:0]  dlyCnt;
  logic [DLY_W-1:0]  dlyLoad;
  logic              enRaw;
  logic              enFall;
  logic              lateLatch;
  logic              slaveLatch;

  always_comb begin
    if (!strobe.frameSec)  loadWord = txPri;
    else if (secValid)     loadWord = txSec;
    else                   loadWord = '0;   // no-op access
    if (strobe.slaveFrame) loadWord[0] = 1'b0;
    if (strobe.slaveFrame)     dlyLoad = DLY_W'(SLAVE_GAP);
    else if (strobe.delayLong) dlyLoad = DLY_W'(LONG_GAP);
    else                       dlyLoad = DLY_W'(SHORT_GAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      wndCnt     <= '0;
      dlyCnt     <= '0;
      secFrame   <= 1'b0;
      lateLatch  <= 1'b0;
      slaveLatch <= 1'b0;
    end else begin
      if (strobe.frameStart) begin
        shiftReg   <= loadWord;
        wndCnt     <= WND_W'(WORD_W);
        secFrame   <= strobe.frameSec;
        lateLatch  <= strobe.lateTurnOn;
        slaveLatch <= strobe.slaveFrame;
      end else if (wndCnt != '0) begin
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        wndCnt   <= wndCnt - 1'b1;
      end
      if (strobe.frameStart)  dlyCnt <= dlyLoad;
      else if (dlyCnt != '0)  dlyCnt <= dlyCnt - 1'b1;
    end
  end

  // Half-bit copy of the window flag used to delay driver turn-on
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) enFall <= 1'b0;
    else       enFall <= enRaw;
  end

  always_comb begin
    enRaw  = (wndCnt != '0);
    sdoEn  = enRaw && (!lateLatch || enFall);
    sdo    = enRaw && shiftReg[WORD_W-1];
    fsdOut = (dlyCnt == DLY_W'(1));
  end

  // R3
  fsd_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsdOut |=> !fsdOut);

  // R5
  win_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enRaw) |-> $past(strobe.frameStart));

  // R6
  slave_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveLatch && wndCnt == WND_W'(1)) |-> !sdo);

endmodule

// File: rtl/frame_relay_port.sv
module frame_relay_port
  import frame_relay_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 32,
  parameter int SLAVE_GAP = 16,
  parameter int MAX_DEV   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       isMaster,
  input  logic                       longSpacing,
  input  logic [$clog2(MAX_DEV)-1:0] chainLen,
  input  logic                       secReq,
  input  logic                       secValid,
  input  logic [WORD_W-1:0]          txPri,
  input  logic [WORD_W-1:0]          txSec,
  input  logic                       fsIn,
  output logic                       fsOut,
  output logic                       fsdOut,
  output logic                       sdo,
  output logic                       sdoEn,
  output logic                       secFrame
);

  relayStrobe_t strobe;

  frame_relay_ctrl #(
    .SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP), .MAX_DEV(MAX_DEV)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .longSpacing(longSpacing),
    .chainLen(chainLen), .secReq(secReq), .fsIn(fsIn),
    .fsOut(fsOut), .strobe(strobe)
  );

  frame_relay_datapath #(
    .WORD_W(WORD_W), .SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP),
    .SLAVE_GAP(SLAVE_GAP)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .secValid(secValid),
    .txPri(txPri), .txSec(txSec), .fsdOut(fsdOut), .sdo(sdo),
    .sdoEn(sdoEn), .secFrame(secFrame)
  );

endmodule

// File: tb/test_frame_relay_port.sv
module test_frame_relay_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isMaster = 1'b1;
  logic        longSpacing = 1'b0;
  logic [2:0]  chainLen = 3'd0;
  logic        secReq = 1'b0;
  logic        secValid = 1'b0;
  logic [15:0] txPri = 16'hA5C3;
  logic [15:0] txSec = 16'h3C5B;
  logic        fsIn = 1'b0;
  logic        fsOut, fsdOut, sdo, sdoEn, secFrame;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  frame_relay_port i_frame_relay_port (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .longSpacing(longSpacing),
    .chainLen(chainLen), .secReq(secReq), .secValid(secValid),
    .txPri(txPri), .txSec(txSec), .fsIn(fsIn), .fsOut(fsOut),
    .fsdOut(fsdOut), .sdo(sdo), .sdoEn(sdoEn), .secFrame(secFrame)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance to the second half of the next cycle
  task automatic step();
    @(posedge clk);
    #15;
  endtask

  task automatic do_reset(input bit master, input bit lng, input logic [2:0] len);
    rstN = 1'b0; isMaster = master; longSpacing = lng; chainLen = len;
    secReq = 1'b0; secValid = 1'b0; fsIn = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
  endtask

  task automatic find_fs(output bit found);
    found = 1'b0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (fsOut) begin found = 1'b1; break; end
    end
  endtask

  // From a frame sync cycle, collect the 16-bit window
  task automatic grab_word(output logic [15:0] w, output bit sec, output int enMiss);
    w = '0; sec = 1'b0; enMiss = 0;
    for (int i = 0; i < 16; i++) begin
      step();
      fsIn = 1'b0;
      w = {w[14:0], sdo};
      if (!sdoEn) enMiss++;
      if (i == 0) sec = secFrame;
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (2) step();
    // R1
    check(!fsOut && !fsdOut && !sdoEn && !sdo && !secFrame, "R1 reset outputs",
          {fsOut, fsdOut, sdoEn, sdo, secFrame}, 0);
  endtask

  // Master round: track fs, fsd and enable over one full round
  task automatic t_master(input bit lng, input logic [2:0] len);
    int gap, rnd, fsBad, fsdBad, enBad;
    bit found;
    logic [15:0] w;
    gap = lng ? 32 : 16;
    rnd = (int'(len) + 1) * gap;
    do_reset(1'b1, lng, len);
    find_fs(found);
    check(found, "R2 master frame sync present", found, 1);
    fsBad = 0; fsdBad = 0; enBad = 0; w = '0;
    for (int k = 1; k <= rnd; k++) begin
      step();
      if (fsOut != (k == rnd)) fsBad++;
      if (fsdOut != (k == gap)) fsdBad++;
      if (sdoEn != (k <= 16)) enBad++;
      if (k <= 16) w = {w[14:0], sdo};
    end
    // R2
    check(fsBad == 0, "R2 fs width and period", fsBad, 0);
    // R3
    check(fsdBad == 0, "R3 delayed sync position", fsdBad, 0);
    // R5
    check(enBad == 0, "R5 enable window", enBad, 0);
    // R5 R7
    check(w == txPri, "R5 R7 primary word msb first", w, txPri);
  endtask

  task automatic t_secondary();
    bit found, sec;
    int miss;
    logic [15:0] w;
    do_reset(1'b1, 1'b0, 3'd0);
    secReq = 1'b1; secValid = 1'b1;
    find_fs(found);
    grab_word(w, sec, miss);
    // R8 R7
    check(!sec && w == txPri, "R8 first round primary", {sec, w}, {1'b0, txPri});
    grab_word(w, sec, miss);
    check(sec && w == txSec && miss == 0, "R8 R7 secondary follows request", {sec, w}, {1'b1, txSec});
    grab_word(w, sec, miss);
    check(!sec, "R8 primary after secondary", sec, 0);
    secValid = 1'b0;
    grab_word(w, sec, miss);
    // R7
    check(sec && w == 16'h0000, "R7 no-op zero word", {sec, w}, {1'b1, 16'h0000});
    secReq = 1'b0;
    grab_word(w, sec, miss);
    grab_word(w, sec, miss);
    // R8
    check(!sec && w == txPri, "R8 no secondary without request", {sec, w}, {1'b0, txPri});
  endtask

  task automatic t_slave();
    int fsdBad, fsBad, enBad;
    logic [15:0] w;
    bit sec;
    int miss;
    do_reset(1'b0, 1'b1, 3'd0);
    repeat (2) step();
    fsIn = 1'b1;
    fsdBad = 0; fsBad = 0; enBad = 0; w = '0;
    for (int k = 1; k <= 20; k++) begin
      step();
      fsIn = 1'b0;
      if (fsdOut != (k == 16)) fsdBad++;
      if (fsOut) fsBad++;
      if (sdoEn != (k <= 16)) enBad++;
      if (k <= 16) w = {w[14:0], sdo};
    end
    // R4
    check(fsdBad == 0 && fsBad == 0, "R4 slave relay at 16 with long spacing", fsdBad + fsBad, 0);
    // R5
    check(enBad == 0, "R5 slave enable window", enBad, 0);
    // R6
    check(w == (txPri & 16'hFFFE), "R6 slave lsb cleared", w, txPri & 16'hFFFE);
    secReq = 1'b1; secValid = 1'b1; fsIn = 1'b1;
    grab_word(w, sec, miss);
    // R9
    check(sec && w == (txSec & 16'hFFFE), "R9 slave secondary frame", {sec, w}, {1'b1, txSec & 16'hFFFE});
    secReq = 1'b0;
    repeat (4) step();
    fsIn = 1'b1;
    grab_word(w, sec, miss);
    check(!sec && w == (txPri & 16'hFFFE), "R9 slave primary frame", {sec, w}, {1'b0, txPri & 16'hFFFE});
  endtask

  task automatic t_late(input bit master, input bit lng);
    bit found;
    bit early, late;
    do_reset(master, lng, 3'd0);
    if (master) begin
      find_fs(found);
    end else begin
      repeat (2) step();
      fsIn = 1'b1;
    end
    @(posedge clk);
    #5;
    fsIn = 1'b0;
    early = sdoEn;
    #10;
    late = sdoEn;
    if (!master && !lng) begin
      // R10
      check(!early && late, "R10 slave short spacing delayed turn-on", {early, late}, 2'b01);
    end else begin
      // R10
      check(early && late, "R10 immediate turn-on", {early, late}, 2'b11);
    end
  endtask

  initial begin
    t_reset();
    t_master(1'b0, 3'd0);
    t_master(1'b1, 3'd2);
    t_master(1'b0, 3'd7);
    t_secondary();
    t_slave();
    t_late(1'b0, 1'b0);
    t_late(1'b0, 1'b1);
    t_late(1'b1, 1'b0);
    t_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule